// File: doc/BRIEF.md
# Quasi-Resonant Switch Cycle Sequencer

This block is the digital heart of a borderline-conduction flyback controller. It receives three single-bit comparator results: one that goes high when the auxiliary winding voltage has dropped below the valley threshold, one that goes high when the primary current sense exceeds the feedback setpoint, and a skip request that is high while the feedback level sits below the skip level. From these it produces the registered gate-drive enable. The drive turns off when the current comparator trips and turns on again at the next valid valley, so each switching period lasts exactly as long as the transformer needs to reset.

Turn-on is gated in three ways. A minimum off-time window follows every drive fall, and its length is picked at run time by a variant pin. A ringing-loss timeout restarts on every valley edge and on every turn-off. If it expires, it may grant the turn-on on its own, and that grant is held as a level until it can be used. A leading-edge blanking window hides the current comparator just after turn-on. Turn-off conditions always win over turn-on conditions, so a valley edge that arrives while skip or a current trip is active is lost, and whole cycles are dropped.

All durations are set in nanoseconds and converted to clock cycles from a clock-frequency parameter. Comparator inputs are resynchronised with two flops. An enable input from the supply and fault manager forces the drive low and clears every timer while it is low.

Top module: `qrs_cycle_seq`

## Requirements
- R1: While `rst` is high the drive is low. After release, with all comparator inputs low, the first turn-on happens exactly max(TOFF, TMO) cycles after the last reset edge. With defaults this is 400 cycles when `fast_sel`=0 and 250 cycles when `fast_sel`=1.
- R2: Each comparator input passes through a two-flop synchroniser. A change applied before edge c+1 acts on `drive_out` at edge c+3.
- R3: A high current-sense input outside the blanking window drives `drive_out` low, and it takes priority over every turn-on condition.
- R4: The current-sense input is ignored for LEB cycles after turn-on (19 by default). A trip held high from turn-on gives an on-time of exactly LEB+1 cycles. A shorter pulse inside the window leaves the drive high.
- R5: No turn-on happens earlier than TOFF cycles after a drive fall. TOFF is 400 cycles when `fast_sel`=0 and 225 cycles when `fast_sel`=1. A valley edge evaluated at cycle TOFF after the fall is accepted; one evaluated at cycle TOFF-1 is lost.
- R6: A rising edge on `dmg_cmp` (high = aux below threshold), seen after the off window has elapsed, turns the drive on. A high level alone does not.
- R7: The timeout counts TMO cycles (250 by default) from the latest drive fall or valley edge. Once it has expired and the off window has elapsed, it turns the drive on as a level condition.
- R8: While `skip_req` is high the drive is held low, and a valley edge in that time is discarded but still restarts the timeout. If the timeout has already expired, the drive rises 3 cycles after `skip_req` falls.
- R9: `en` low drives `drive_out` low at the next edge and clears all timers. After `en` returns, behaviour is the same as after reset (R1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable from the supply/fault manager (synchronous) |
| fast_sel | input | 1 | Off-window variant: 0 long, 1 short |
| dmg_cmp | input | 1 | Valley comparator, high when aux is below threshold (asynchronous) |
| cs_cmp | input | 1 | Current comparator, high when sense exceeds setpoint (asynchronous) |
| skip_req | input | 1 | Skip request, high while feedback is below skip level (asynchronous) |
| drive_out | output | 1 | Registered gate-drive enable |

## Verification
A wrong count in the off-window or timeout counters appears as a turn-on edge that is early or late by whole cycles. The bench therefore measures every turn-on to the exact cycle against an arithmetic expectation, sweeping the valley arrival across the off-window boundary for both variants. A blanking counter that stops early or late shifts the on-time under a held trip away from LEB+1, which is visible on the first pulse. A wrongly ordered priority shows up either when the skip request is released or as an extra pulse during skip, within one cycle of the faulty decision.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  // Convert a duration in ns to clock cycles, rounding up.
  function automatic int ns2cyc(input int ns, input int clk_mhz);
    return (ns * clk_mhz + 999) / 1000;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/qrs_sync.sv
module qrs_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  // R2: two flops per bit
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        meta[i] <= 1'b0;
        q[i]    <= 1'b0;
      end else begin
        meta[i] <= d_async[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/qrs_timer.sv
module qrs_timer #(
  parameter int MAXV = 400,
  localparam int CW  = $clog2(MAXV + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] thr,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (cnt < CW'(MAXV)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done = (cnt >= thr);
endmodule

// File: rtl/qrs_drive_latch.sv
module qrs_drive_latch (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rst_lvl,
  input  logic set_edge,
  input  logic set_lvl,
  output logic drive_q
);
  // Reset level wins over both set paths (R3, R8).
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      drive_q <= 1'b0;
    end else if (rst_lvl) begin
      drive_q <= 1'b0;
    end else if (set_edge || set_lvl) begin
      drive_q <= 1'b1;
    end
  end
endmodule

// File: rtl/qrs_cycle_seq.sv
module qrs_cycle_seq
  import qrs_pkg::*;
#(
  parameter int CLK_MHZ   = 50,
  parameter int LEB_NS    = 380,
  parameter int TOFF_A_NS = 8000,
  parameter int TOFF_B_NS = 4500,
  parameter int TMO_NS    = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic fast_sel,
  input  logic dmg_cmp,
  input  logic cs_cmp,
  input  logic skip_req,
  output logic drive_out
);
  localparam int LEB_C   = ns2cyc(LEB_NS, CLK_MHZ);
  localparam int TA_C    = ns2cyc(TOFF_A_NS, CLK_MHZ);
  localparam int TB_C    = ns2cyc(TOFF_B_NS, CLK_MHZ);
  localparam int TMO_C   = ns2cyc(TMO_NS, CLK_MHZ);
  localparam int OFF_MAX = imax(TA_C, TB_C) - 1;
  localparam int OFF_W   = $clog2(OFF_MAX + 1);
  localparam int LEB_W   = $clog2(LEB_C + 1);
  localparam int TMO_W   = $clog2(TMO_C);

  logic [2:0] sync_q;
  logic       dmg_s, cs_s, skip_s, dmg_d, dmg_edge;
  logic       drive_q, leb_done, off_done, tmo_done;
  logic [OFF_W-1:0] off_thr;

  qrs_sync #(.W(3)) sync_i (
    .clk(clk), .rst(rst),
    .d_async({skip_req, cs_cmp, dmg_cmp}),
    .q(sync_q)
  );
  assign dmg_s  = sync_q[0];
  assign cs_s   = sync_q[1];
  assign skip_s = sync_q[2];

  // R6: valley event is the rising edge of the synchronised comparator
  always_ff @(posedge clk) begin
    if (rst) dmg_d <= 1'b0;
    else     dmg_d <= dmg_s;
  end
  assign dmg_edge = dmg_s & ~dmg_d;

  // R4: blanking after turn-on
  qrs_timer #(.MAXV(LEB_C)) leb_i (
    .clk(clk), .rst(rst), .clr(!drive_q || !en),
    .thr(LEB_W'(LEB_C)), .done(leb_done)
  );

  // R5: minimum off window, variant chosen at run time
  generate
    if (TA_C == TB_C) begin : g_one_off
      assign off_thr = OFF_W'(TA_C - 1);
    end else begin : g_two_off
      assign off_thr = fast_sel ? OFF_W'(TB_C - 1) : OFF_W'(TA_C - 1);
    end
  endgenerate

  qrs_timer #(.MAXV(OFF_MAX)) off_i (
    .clk(clk), .rst(rst), .clr(drive_q || !en),
    .thr(off_thr), .done(off_done)
  );

  // R7: ringing-loss timeout, restarted by every valley edge
  qrs_timer #(.MAXV(TMO_C - 1)) tmo_i (
    .clk(clk), .rst(rst), .clr(drive_q || dmg_edge || !en),
    .thr(TMO_W'(TMO_C - 1)), .done(tmo_done)
  );

  qrs_drive_latch latch_i (
    .clk(clk), .rst(rst), .en(en),
    .rst_lvl(skip_s || (cs_s && (leb_done || !drive_q))),
    .set_edge(dmg_edge && off_done),
    .set_lvl(tmo_done && off_done),
    .drive_q(drive_q)
  );

  assign drive_out = drive_q;
endmodule

// File: rtl/qrs_cycle_seq_chk.sv
module qrs_cycle_seq_chk
  import qrs_pkg::*;
#(
  parameter int CLK_MHZ   = 50,
  parameter int LEB_NS    = 380,
  parameter int TOFF_A_NS = 8000,
  parameter int TOFF_B_NS = 4500
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic fast_sel,
  input logic skip_s,
  input logic drive_out
);
  localparam int LEB_C = ns2cyc(LEB_NS, CLK_MHZ);
  localparam int TA_C  = ns2cyc(TOFF_A_NS, CLK_MHZ);
  localparam int TB_C  = ns2cyc(TOFF_B_NS, CLK_MHZ);
  localparam int CAP   = 1 << 20;

  int off_run, on_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      off_run <= 0;
      on_run  <= 0;
    end else begin
      off_run <= drive_out ? 0 : ((off_run < CAP) ? off_run + 1 : off_run);
      on_run  <= !drive_out ? 0 : ((on_run < CAP) ? on_run + 1 : on_run);
    end
  end

  a_r1_reset_low: assert property (@(posedge clk) rst |=> !drive_out);

  a_r9_enable_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !drive_out);

  a_r8_skip_hold: assert property (@(posedge clk) disable iff (rst)
    skip_s |=> !drive_out);

  a_r5_min_off: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_out) |-> ($past(off_run) >= ($past(fast_sel) ? TB_C - 1 : TA_C - 1)));

  a_r4_blank_on: assert property (@(posedge clk) disable iff (rst)
    ($fell(drive_out) && $past(en) && !$past(skip_s)) |-> ($past(on_run) >= LEB_C));
endmodule

bind qrs_cycle_seq qrs_cycle_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .LEB_NS(LEB_NS), .TOFF_A_NS(TOFF_A_NS), .TOFF_B_NS(TOFF_B_NS)
) chk_i (
  .clk(clk), .rst(rst), .en(en), .fast_sel(fast_sel),
  .skip_s(skip_s), .drive_out(drive_out)
);

// File: tb/qrs_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module qrs_cycle_seq_tb_top;
  localparam int T_A = (8000 * 50 + 999) / 1000;
  localparam int T_B = (4500 * 50 + 999) / 1000;
  localparam int TMO = (5000 * 50 + 999) / 1000;
  localparam int LEB = (380 * 50 + 999) / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b1, fast_sel = 1'b0;
  logic dmg_cmp = 1'b0, cs_cmp = 1'b0, skip_req = 1'b0;
  logic drive_out;
  int cyc = 0;
  int total = 0, bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  qrs_cycle_seq dut_i (
    .clk(clk), .rst(rst), .en(en), .fast_sel(fast_sel),
    .dmg_cmp(dmg_cmp), .cs_cmp(cs_cmp), .skip_req(skip_req),
    .drive_out(drive_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected turn-on offset after a fall, valley pulse applied k cycles after it.
  function automatic int exp_rise(input int t, input int k);
    int e, m;
    e = k + 3;
    m = mx(t, TMO);
    if (e >= m) return m;
    if (e >= t) return e;
    return mx(t, e + TMO);
  endfunction

  task automatic wait_level(input logic v, output int t);
    t = -1;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (drive_out == v) begin
        t = cyc;
        return;
      end
    end
  endtask

  // Produce a fall from the high state with a current trip; returns fall cycle.
  task automatic force_fall(output int f);
    int c0;
    repeat (30) @(negedge clk);
    cs_cmp = 1'b1;
    c0 = cyc;
    wait_level(1'b0, f);
    chk(f == c0 + 3, "R2 R3 trip to fall latency", f - c0, 3);
    cs_cmp = 1'b0;
  endtask

  // From the fall cycle f, apply valley pulses and skip window; return rise offset.
  task automatic run_off(input int f, input int k1, input int k2,
                         input int s_on, input int s_off, output int rise);
    int rel;
    rise = -1;
    for (int i = 0; i < 3000; i++) begin
      rel = cyc - f;
      dmg_cmp  = ((k1 >= 0) && rel >= k1 && rel < k1 + 4) ||
                 ((k2 >= 0) && rel >= k2 && rel < k2 + 4);
      skip_req = (s_on >= 0) && rel >= s_on && rel < s_off;
      if (drive_out && rise < 0) rise = rel;
      if (rise >= 0 && rel > k1 + 4 && rel > k2 + 4 && rel >= s_off) break;
      @(negedge clk);
    end
    dmg_cmp = 1'b0;
    skip_req = 1'b0;
  endtask

  task automatic sweep(input logic fs, input int k, input string req);
    int f, r, t;
    t = fs ? T_B : T_A;
    fast_sel = fs;
    force_fall(f);
    run_off(f, k, -1, -1, 0, r);
    chk(r == exp_rise(t, k), req, r, exp_rise(t, k));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int r0, t, f, e, c, r;
    repeat (5) @(negedge clk);
    chk(drive_out == 1'b0, "R1 low in reset", drive_out, 0);
    rst = 1'b0;
    r0 = cyc;
    wait_level(1'b1, t);
    chk(t == r0 + mx(T_A, TMO), "R1 first turn-on", t - r0, mx(T_A, TMO));

    // R4: glitch inside blanking window is ignored
    cs_cmp = 1'b1;
    repeat (5) @(negedge clk);
    cs_cmp = 1'b0;
    while (cyc < t + 30) @(negedge clk);
    chk(drive_out == 1'b1, "R4 short trip in blanking", drive_out, 1);

    // R3 / R5: trip then timeout-only restart at the off window
    force_fall(f);
    wait_level(1'b1, e);
    chk(e - f == T_A, "R5 restart at min off", e - f, T_A);

    // R4: trip held from turn-on
    cs_cmp = 1'b1;
    wait_level(1'b0, t);
    chk(t - e == LEB + 1, "R4 held trip on-time", t - e, LEB + 1);
    cs_cmp = 1'b0;
    f = t;

    // R6: two valley pulses, second one after the window turns on
    run_off(f, 200, 420, -1, 0, r);
    chk(r == 423, "R6 valley turn-on", r, 423);

    // R7: timeout restarts at a valley edge
    force_fall(f);
    run_off(f, 200, -1, -1, 0, r);
    chk(r == 453, "R7 timeout restart", r, 453);

    // R6: level alone without new edge does not turn on before timeout
    force_fall(f);
    run_off(f, 100, -1, -1, 0, r);
    chk(r == exp_rise(T_A, 100), "R6 early edge lost", r, exp_rise(T_A, 100));

    // R8: skip holds, release grants turn-on via expired timeout
    force_fall(f);
    run_off(f, -1, -1, 10, 600, r);
    chk(r == 603, "R8 skip release", r, 603);
    force_fall(f);
    run_off(f, 500, -1, 10, 600, r);
    chk(r == 753, "R8 valley during skip discarded", r, 753);

    // R8: skip while high turns drive off without blanking
    repeat (5) @(negedge clk);
    skip_req = 1'b1;
    c = cyc;
    wait_level(1'b0, t);
    chk(t - c == 3, "R8 skip forces off", t - c, 3);
    skip_req = 1'b0;
    wait_level(1'b1, t);

    // R5 / R6 / R7 sweeps across the off-window boundary, both variants
    sweep(1'b0, 300, "R7 sweep long k=300");
    for (int k = 393; k <= 399; k++) sweep(1'b0, k, "R5 sweep long window edge");
    sweep(1'b1, 100, "R7 sweep short k=100");
    for (int k = 218; k <= 224; k++) sweep(1'b1, k, "R5 sweep short window edge");
    sweep(1'b1, 240, "R6 sweep short k=240");
    sweep(1'b1, 260, "R7 sweep short timeout first");

    // R9: enable drop and return (short variant active)
    @(negedge clk);
    en = 1'b0;
    c = cyc;
    @(negedge clk);
    chk(drive_out == 1'b0, "R9 enable forces off", drive_out, 0);
    repeat (10) @(negedge clk);
    dmg_cmp = 1'b1;
    repeat (4) @(negedge clk);
    dmg_cmp = 1'b0;
    repeat (40) @(negedge clk);
    chk(drive_out == 1'b0, "R9 held off while disabled", drive_out, 0);
    en = 1'b1;
    c = cyc;
    wait_level(1'b1, t);
    chk(t - c == mx(T_B, TMO), "R9 restart after enable", t - c, mx(T_B, TMO));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule